// File: doc/BRIEF.md
# Port Indicator LED Controller

This block drives the status lights of a hub with several downstream ports. Each port has one bidirectional pin. A green and an amber LED sit between that pin and one shared, bidirectional common pin, wired in opposite directions, so the polarity across the pair picks the colour. An optional hub-active LED sits between the common pin and ground.

The same pins act as board straps while the block is in reset. After reset the block turns on weak pull-ups for a fixed number of clocks and then samples the pins. A common pin held low means the board carries no indicators, and every pin stays undriven from then on. A port pin held low marks that port's device as non-removable, and that pin is never driven. Once sampling is complete, the pull-ups turn off and the straps are frozen.

After the strap phase, the block time-multiplexes the common pin across a fixed rotation. There is one slot per port in ascending order, then one slot for the hub-active LED. In each port slot, a per-port two-bit selector and the port's live state from the hub controller decide the colour. In the hub slot, the hub's configured and suspended state decide whether the hub-active LED is lit.

Top module: `port_ind_ctrl`

## Requirements
- R1: After reset, `pullup_en_o` is 1 and every output enable is 0 for `STRAP_CYCLES` clock edges. `strap_done_o` rises on edge `STRAP_CYCLES`, and `pullup_en_o` falls with it.
- R2: If `com_i` is 0 at the end of the strap phase, `ind_supported_o` is 0 and no pin is ever driven: `led_oe_o` stays 0 and `com_oe_o` stays 0.
- R3: If `led_i[p]` is 0 at the end of the strap phase, `nonremovable_o[p]` is 1 and `led_oe_o[p]` is never set.
- R4: Selector field `sel_i[2p+1:2p]` sets port p's colour: code 0 is automatic, code 1 is amber, code 2 is green and code 3 is off.
- R5: In automatic mode, `port_fault_i[p]` = 1 gives amber, whether or not the port is enabled. Otherwise `port_en_i[p]` = 1 gives green. Otherwise the port is off.
- R6: A green port is shown as `led_o[p]`=1 with `com_o`=0. An amber port is shown as `led_o[p]`=0 with `com_o`=1. In both cases `led_oe_o[p]` and `com_oe_o` are 1. An off port enables no pin.
- R7: Slots rotate through port 0 up to port NPORT-1 and then the hub slot. Each slot lasts `DWELL` cycles, and at most one `led_oe_o` bit is set at any time.
- R8: In the hub slot, `com_oe_o` is 1, every `led_oe_o` bit is 0, and `com_o` is 1 exactly when the hub was configured and not suspended on the previous cycle. The LED turns on at configuration or resume, and turns off at suspend or unconfiguration.
- R9: A port whose pin is high or floating at strap time counts as removable. With indicators supported, that port is lit normally even if no LED is fitted.
- R10: Once `strap_done_o` is 1, later changes on `led_i` and `com_i` leave `ind_supported_o` and `nonremovable_o` unchanged, and the pull-ups stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts strap sampling |
| sel_i | input | 2*NPORT | Per-port indicator selector, two bits per port |
| port_en_i | input | NPORT | Port enabled |
| port_fault_i | input | NPORT | Port over-current or error condition |
| hub_cfg_i | input | 1 | Hub configured by host |
| hub_susp_i | input | 1 | Hub suspended |
| led_i | input | NPORT | Sensed level of each port pin |
| led_o | output | NPORT | Drive value of each port pin |
| led_oe_o | output | NPORT | Output enable of each port pin |
| com_i | input | 1 | Sensed level of the common pin |
| com_o | output | 1 | Drive value of the common pin |
| com_oe_o | output | 1 | Output enable of the common pin |
| pullup_en_o | output | 1 | Weak pull-ups on during strap sampling |
| strap_done_o | output | 1 | Strap phase finished |
| ind_supported_o | output | 1 | Indicators fitted (common pin strap) |
| nonremovable_o | output | NPORT | Per-port non-removable device strap |

## Verification
Colour decoding is tried with all four ports given different selector codes at once, so that a swapped code or a swapped port index shows up as a wrong colour on a specific port. Automatic mode is driven with fault alone, with fault and enable together, with enable alone, and with neither, which separates fault priority from the enable path. The rotation is observed with every port green and the hub LED on, which exposes a wrong slot order or a wrong dwell. Strap patterns with mixed removable and non-removable ports, and with the common pin low, show whether driving is suppressed on exactly the right pins.

// File: rtl/port_ind_pkg.sv
package port_ind_pkg;
   typedef enum logic [1:0] {
      COL_OFF   = 2'd0,
      COL_GREEN = 2'd1,
      COL_AMBER = 2'd2
   } ind_col_e;

   localparam logic [1:0] SEL_AUTO  = 2'd0;
   localparam logic [1:0] SEL_AMBER = 2'd1;
   localparam logic [1:0] SEL_GREEN = 2'd2;
   localparam logic [1:0] SEL_OFF   = 2'd3;
endpackage

// File: rtl/pil_strap.sv
module pil_strap #(
   parameter int NPORT        = 4,
   parameter int STRAP_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] led_i,
   input  logic             com_i,
   output logic             done_o,
   output logic             supported_o,
   output logic [NPORT-1:0] nonrem_o
);
   localparam int CNT_W = $clog2(STRAP_CYCLES);

   generate
      if (STRAP_CYCLES < 2) begin : g_bad_strap
         $error("STRAP_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         done_o      <= 1'b0;
         supported_o <= 1'b0;
         nonrem_o    <= '0;
      end else if (!done_o) begin
         if (cnt_q == CNT_W'(STRAP_CYCLES - 1)) begin
            done_o      <= 1'b1;
            supported_o <= com_i;
            nonrem_o    <= ~led_i;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(done_o)) |-> ($stable(nonrem_o) && $stable(supported_o))); // R10
endmodule

// File: rtl/pil_colour.sv
module pil_colour
   import port_ind_pkg::*;
#(
   parameter int NPORT = 4
) (
   input  logic [2*NPORT-1:0]        sel_i,
   input  logic [NPORT-1:0]          en_i,
   input  logic [NPORT-1:0]          fault_i,
   output ind_col_e [NPORT-1:0]      colour_o
);
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [1:0] code;
      assign code = sel_i[2*p +: 2];
      always_comb begin
         unique case (code)
            SEL_AMBER: colour_o[p] = COL_AMBER;
            SEL_GREEN: colour_o[p] = COL_GREEN;
            SEL_OFF:   colour_o[p] = COL_OFF;
            default: begin
               if (fault_i[p])   colour_o[p] = COL_AMBER;
               else if (en_i[p]) colour_o[p] = COL_GREEN;
               else              colour_o[p] = COL_OFF;
            end
         endcase
      end
   end
endmodule

// File: rtl/pil_slot.sv
module pil_slot #(
   parameter int NPORT = 4,
   parameter int DWELL = 4,
   localparam int SLOT_W = $clog2(NPORT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   output logic [SLOT_W-1:0] slot_o
);
   localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;

   generate
      if (DWELL < 1) begin : g_bad_dwell
         $error("DWELL must be at least 1");
      end
   endgenerate

   logic [DW_W-1:0] dcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt_q <= '0;
         slot_o <= '0;
      end else if (run_i) begin
         if (dcnt_q == DW_W'(DWELL - 1)) begin
            dcnt_q <= '0;
            slot_o <= (slot_o == SLOT_W'(NPORT)) ? '0 : slot_o + 1'b1;
         end else begin
            dcnt_q <= dcnt_q + 1'b1;
         end
      end
   end

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_o <= SLOT_W'(NPORT)); // R7
endmodule

// File: rtl/port_ind_ctrl.sv
module port_ind_ctrl
   import port_ind_pkg::*;
#(
   parameter int NPORT        = 4,
   parameter int STRAP_CYCLES = 8,
   parameter int DWELL        = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NPORT-1:0] sel_i,
   input  logic [NPORT-1:0]   port_en_i,
   input  logic [NPORT-1:0]   port_fault_i,
   input  logic               hub_cfg_i,
   input  logic               hub_susp_i,
   input  logic [NPORT-1:0]   led_i,
   output logic [NPORT-1:0]   led_o,
   output logic [NPORT-1:0]   led_oe_o,
   input  logic               com_i,
   output logic               com_o,
   output logic               com_oe_o,
   output logic               pullup_en_o,
   output logic               strap_done_o,
   output logic               ind_supported_o,
   output logic [NPORT-1:0]   nonremovable_o
);
   localparam int SLOT_W = $clog2(NPORT + 1);

   generate
      if (NPORT < 1) begin : g_bad_nport
         $error("NPORT must be at least 1");
      end
   endgenerate

   ind_col_e [NPORT-1:0] colour;
   logic [SLOT_W-1:0]    slot;
   logic                 act_q;

   pil_strap #(.NPORT(NPORT), .STRAP_CYCLES(STRAP_CYCLES)) u_strap (
      .clk(clk), .rst_n(rst_n), .led_i(led_i), .com_i(com_i),
      .done_o(strap_done_o), .supported_o(ind_supported_o),
      .nonrem_o(nonremovable_o)
   );

   pil_colour #(.NPORT(NPORT)) u_colour (
      .sel_i(sel_i), .en_i(port_en_i), .fault_i(port_fault_i),
      .colour_o(colour)
   );

   pil_slot #(.NPORT(NPORT), .DWELL(DWELL)) u_slot (
      .clk(clk), .rst_n(rst_n), .run_i(strap_done_o), .slot_o(slot)
   );

   assign pullup_en_o = !strap_done_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= hub_cfg_i && !hub_susp_i;
   end

   always_comb begin
      led_o    = '0;
      led_oe_o = '0;
      com_o    = 1'b0;
      com_oe_o = 1'b0;
      if (strap_done_o && ind_supported_o) begin
         if (slot == SLOT_W'(NPORT)) begin
            com_oe_o = 1'b1;
            com_o    = act_q;
         end
         for (int p = 0; p < NPORT; p++) begin
            if (slot == SLOT_W'(p) && !nonremovable_o[p] && colour[p] != COL_OFF) begin
               led_oe_o[p] = 1'b1;
               com_oe_o    = 1'b1;
               led_o[p]    = (colour[p] == COL_GREEN);
               com_o       = (colour[p] == COL_AMBER);
            end
         end
      end
   end

   AST_QUIET_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_done_o |-> (led_oe_o == '0 && !com_oe_o && pullup_en_o)); // R1
   AST_UNSUP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !ind_supported_o |-> (led_oe_o == '0 && !com_oe_o)); // R2
   AST_NONREM_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (led_oe_o & nonremovable_o) == '0); // R3
   AST_GREEN_POL: assert property (@(posedge clk) disable iff (!rst_n)
      |(led_oe_o & led_o) |-> (com_oe_o && !com_o)); // R6
   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(led_oe_o)); // R7
   AST_HUB_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      hub_susp_i |=> !act_q); // R8
endmodule

// File: tb/tb_port_ind_ctrl.sv
module tb_port_ind_ctrl;
   localparam int NP  = 4;
   localparam int SC  = 8;
   localparam int DW  = 3;
   localparam int CLK_PERIOD = 10;
   localparam int ROT = (NP + 1) * DW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2*NP-1:0] sel_i = '0;
   logic [NP-1:0]   port_en_i = '0, port_fault_i = '0;
   logic            hub_cfg_i = 1'b0, hub_susp_i = 1'b0;
   logic [NP-1:0]   led_i = '1;
   logic [NP-1:0]   led_o, led_oe_o, nonremovable_o;
   logic            com_i = 1'b1;
   logic            com_o, com_oe_o, pullup_en_o, strap_done_o, ind_supported_o;

   int checks = 0;
   int fails  = 0;

   logic [NP-1:0] seen_g, seen_a;
   int            hub_lit, any_drive, multi;

   port_ind_ctrl #(.NPORT(NP), .STRAP_CYCLES(SC), .DWELL(DW)) dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic com_strap, input logic [NP-1:0] led_strap);
      @(negedge clk);
      rst_n = 1'b0;
      com_i = com_strap;
      led_i = led_strap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 1; k < SC; k++) begin
         @(negedge clk);
         check(!strap_done_o && pullup_en_o && led_oe_o == '0 && !com_oe_o,
               "R1 strap phase quiet", {strap_done_o, pullup_en_o, com_oe_o}, 3'b010);
      end
      @(negedge clk);
      check(strap_done_o && !pullup_en_o, "R1 strap done edge",
            {strap_done_o, pullup_en_o}, 2'b10);
   endtask

   task automatic observe(input int cycles);
      seen_g = '0; seen_a = '0; hub_lit = 0; any_drive = 0; multi = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         if (led_oe_o != '0 || com_oe_o) any_drive++;
         if ($countones(led_oe_o) > 1) multi++;
         for (int p = 0; p < NP; p++) begin
            if (led_oe_o[p] && com_oe_o && led_o[p] && !com_o) seen_g[p] = 1'b1;
            if (led_oe_o[p] && com_oe_o && !led_o[p] && com_o) seen_a[p] = 1'b1;
         end
         if (led_oe_o == '0 && com_oe_o && com_o) hub_lit++;
      end
   endtask

   task automatic t_colours();
      // port0 auto+en, port1 amber, port2 green, port3 off
      port_en_i = 4'b1111; port_fault_i = '0;
      sel_i = {2'd3, 2'd2, 2'd1, 2'd0};
      repeat (2) @(negedge clk);
      observe(2 * ROT);
      check(seen_g == 4'b0101, "R4 green codes", seen_g, 4'b0101);
      check(seen_a == 4'b0010, "R4 amber code", seen_a, 4'b0010);
      check(multi == 0, "R7 one port at a time", multi, 0);
      // all auto: p0 fault only, p1 fault+en, p2 en only, p3 neither
      sel_i = '0;
      port_fault_i = 4'b0011; port_en_i = 4'b0110;
      repeat (2) @(negedge clk);
      observe(2 * ROT);
      check(seen_a == 4'b0011, "R5 auto fault amber", seen_a, 4'b0011);
      check(seen_g == 4'b0100, "R5 auto enable green", seen_g, 4'b0100);
      check((seen_g | seen_a) == 4'b0111, "R6 off port undriven", seen_g | seen_a, 4'b0111);
      port_fault_i = '0;
   endtask

   task automatic t_rotation();
      int cnt[NP+1];
      int prev, id, bad;
      sel_i = {NP{2'd2}};
      hub_cfg_i = 1'b1; hub_susp_i = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i <= NP; i++) cnt[i] = 0;
      prev = -1; bad = 0;
      for (int c = 0; c < ROT; c++) begin
         @(negedge clk);
         id = -1;
         for (int p = 0; p < NP; p++) if (led_oe_o == (NP'(1) << p)) id = p;
         if (led_oe_o == '0 && com_oe_o && com_o) id = NP;
         if (id < 0) bad++;
         else begin
            cnt[id]++;
            if (prev >= 0 && id != prev && id != (prev + 1) % (NP + 1)) bad++;
            prev = id;
         end
      end
      check(bad == 0, "R7 slot order", bad, 0);
      for (int i = 0; i <= NP; i++)
         check(cnt[i] == DW, "R7 slot dwell", cnt[i], DW);
   endtask

   task automatic t_hub();
      sel_i = {NP{2'd3}};
      hub_cfg_i = 1'b1; hub_susp_i = 1'b0;
      repeat (2) @(negedge clk);
      observe(ROT);
      check(hub_lit == DW, "R8 configured lit", hub_lit, DW);
      check(any_drive == DW, "R8 only hub slot drives", any_drive, DW);
      hub_susp_i = 1'b1;
      repeat (2) @(negedge clk);
      observe(ROT);
      check(hub_lit == 0, "R8 suspended dark", hub_lit, 0);
      check(any_drive == DW, "R8 hub slot drives low", any_drive, DW);
      hub_susp_i = 1'b0;
      repeat (2) @(negedge clk);
      observe(ROT);
      check(hub_lit == DW, "R8 resume lit", hub_lit, DW);
      hub_cfg_i = 1'b0;
      repeat (2) @(negedge clk);
      observe(ROT);
      check(hub_lit == 0, "R8 unconfigured dark", hub_lit, 0);
   endtask

   task automatic t_nonrem();
      do_reset(1'b1, 4'b1010);
      check(nonremovable_o == 4'b0101, "R3 nonremovable straps", nonremovable_o, 4'b0101);
      check(ind_supported_o == 1'b1, "R9 supported", ind_supported_o, 1);
      sel_i = {NP{2'd2}};
      led_i = '1;
      @(negedge clk);
      observe(2 * ROT);
      check(seen_g == 4'b1010, "R9 removable lit R3 fixed dark", seen_g, 4'b1010);
   endtask

   task automatic t_frozen();
      led_i = 4'b0000; com_i = 1'b0;
      repeat (3) @(negedge clk);
      check(nonremovable_o == 4'b0101 && ind_supported_o,
            "R10 straps frozen", {ind_supported_o, nonremovable_o}, 5'h15);
      check(!pullup_en_o, "R10 pullups stay off", pullup_en_o, 0);
      led_i = '1; com_i = 1'b1;
   endtask

   task automatic t_unsup();
      do_reset(1'b0, 4'b1111);
      check(ind_supported_o == 1'b0, "R2 unsupported flag", ind_supported_o, 0);
      sel_i = {NP{2'd1}};
      hub_cfg_i = 1'b1; hub_susp_i = 1'b0;
      com_i = 1'b1;
      observe(2 * ROT);
      check(any_drive == 0, "R2 nothing driven", any_drive, 0);
   endtask

   initial begin
      do_reset(1'b1, 4'b1111);
      check(ind_supported_o && nonremovable_o == '0, "R1 reset straps",
            {ind_supported_o, nonremovable_o}, 5'h10);
      t_colours();
      t_rotation();
      t_hub();
      t_nonrem();
      t_frozen();
      t_unsup();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule